// File: doc/BRIEF.md
# Delay-Line Sampling Phase Loader

This block walks a delay-line control word through the ordered steps needed to change the receive sampling phase safely. A one-cycle start pulse supplies a binary phase number from 0 to 15 and a snapshot of the current 32-bit control word. The block first parks the clock-recovery logic on the externally selected phase and gates the delay line's output clock off. It waits until the delay line confirms that the clock is off. It then writes the phase, converted to Gray code, and turns the output clock back on. Once that is confirmed, it hands control back to the recovery loop.

Each confirmation is a poll of a status bit returned by the delay line. A 1 µs tick input paces the poll, and the number of checks it may make is bounded. If a poll runs out of checks, the sequence stops where it is and reports an error instead of completing. The control word is held in a register inside the block and driven on `cfg_o` at all times. Bits the sequence does not name keep the value captured at start.

Top module: `dll_phase_seq`

## Requirements
- R1: While reset is held and after it is released, `cfg_o` is all zero and `busy_o`, `done_o` and `err_o` are low.
- R2: A start pulse while idle produces one update of `cfg_o` in the next cycle, built from `cfg_base_i` as follows. Bits 16 (delay-line enable) and 19 (external phase select) are set. Bits 17 (recovery enable) and 18 (output clock enable) are cleared. `busy_o` rises in that same cycle.
- R3: The phase field is not written and bit 18 is not set again until a poll check has read `ck_stat_i` as 0.
- R4: The phase field is `cfg_o[23:20]`. Phase numbers 0 to 15 are written as the codes 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8, in that order.
- R5: Bit 18 is set after the phase write, and the block then polls until `ck_stat_i` reads 1.
- R6: On success, the final update sets bit 17 and clears bit 19. `done_o` then pulses in the cycle in which `busy_o` falls, and the word ends as bits 16, 17 and 18 set, bit 19 clear.
- R7: A poll check happens only in a cycle where `tick_i` is high. After POLL_CHECKS consecutive failed checks in one poll, `err_o` pulses, `busy_o` falls, and none of the remaining steps is applied.
- R8: A start pulse while `busy_o` is high is ignored: neither its phase nor its `cfg_base_i` reaches `cfg_o`, and no extra `done_o` follows.
- R9: Bits 31:24 and 15:0 of `cfg_o` equal those of `cfg_base_i` sampled at start and do not change while busy, whatever `cfg_base_i` does later.
- R10: `done_o` and `err_o` are each high for exactly one cycle per sequence and never together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| start_i | input | 1 | One-cycle request to load a new phase |
| phase_i | input | 4 | Binary phase number, sampled with the start pulse |
| cfg_base_i | input | 32 | Current control word, sampled with the start pulse |
| tick_i | input | 1 | 1 µs pacing pulse for status checks |
| ck_stat_i | input | 1 | Output-clock-enable status returned by the delay line |
| cfg_o | output | 32 | Control word image driven to the delay line |
| busy_o | output | 1 | High from the cycle after start until completion |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | One-cycle pulse when a poll runs out of checks |

## Verification
The bench builds the block with POLL_CHECKS set to 5 and supplies a tick every third clock. This keeps an expired poll down to about fifteen cycles, so both timeout paths can be reached, and the bench can count exactly how many ticks are consumed before the error. A status model follows bit 18 after a lag of 0 to 9 clocks. With it, every one of the sixteen phase codes is exercised with a different response time, and two stuck modes (status held at 1, status held at 0) make the first or the second poll fail.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int unsigned CFG_W       = 32;
  localparam int unsigned PH_W        = 4;
  localparam int unsigned BIT_DLL_EN  = 16;
  localparam int unsigned BIT_CDR_EN  = 17;
  localparam int unsigned BIT_CK_OUT  = 18;
  localparam int unsigned BIT_CDR_EXT = 19;
  localparam int unsigned FIELD_LO    = 20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_OFF,
    ST_WR_PHASE,
    ST_SET_OUT,
    ST_WAIT_ON,
    ST_FINISH
  } seq_state_e;
endpackage

// File: rtl/dps_rst_sync.sv
module dps_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/dps_gray.sv
module dps_gray #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_msb
      assign gray_o[i] = bin_i[i];
    end else begin : g_low
      assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
    end
  end
endmodule

// File: rtl/dps_poll_timer.sv
module dps_poll_timer #(
  parameter int unsigned CHECKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic active_i,
  input  logic tick_i,
  input  logic stat_i,
  input  logic want_i,
  output logic hit_o,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(CHECKS + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;
  logic          check, miss;

  assign check    = active_i & tick_i;
  assign miss     = check & (stat_i != want_i);
  assign hit_o    = check & (stat_i == want_i);
  assign expire_o = miss & (cnt_q == CW'(CHECKS - 1));

  always_comb begin
    cnt_en = arm_i | (miss & ~expire_o);
    cnt_n  = arm_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  // R7: the failed-check count never reaches the limit while held
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(CHECKS));
endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq
  import dps_pkg::*;
#(
  parameter int unsigned POLL_CHECKS = 50
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic [CFG_W-1:0] cfg_base_i,
  input  logic             tick_i,
  input  logic             ck_stat_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  logic             rst_n;
  seq_state_e       state_q, state_n;
  logic [CFG_W-1:0] cfg_q, cfg_n;
  logic             cfg_we;
  logic [PH_W-1:0]  phase_q;
  logic             phase_we;
  logic [PH_W-1:0]  gray_w;
  logic             done_q, done_n, err_q, err_n;
  logic             arm, poll_active, want_on, hit, expire;

  dps_rst_sync u_rst (.clk(clk), .rst_ni(rst_ni), .rst_no(rst_n));

  dps_gray #(.W(PH_W)) u_gray (.bin_i(phase_q), .gray_o(gray_w));

  assign poll_active = (state_q == ST_WAIT_OFF) || (state_q == ST_WAIT_ON);
  assign want_on     = (state_q == ST_WAIT_ON);

  dps_poll_timer #(.CHECKS(POLL_CHECKS)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (arm),
    .active_i(poll_active),
    .tick_i  (tick_i),
    .stat_i  (ck_stat_i),
    .want_i  (want_on),
    .hit_o   (hit),
    .expire_o(expire)
  );

  always_comb begin
    state_n  = state_q;
    cfg_n    = cfg_q;
    cfg_we   = 1'b0;
    phase_we = 1'b0;
    done_n   = 1'b0;
    err_n    = 1'b0;
    arm      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cfg_n              = cfg_base_i;
          cfg_n[BIT_DLL_EN]  = 1'b1;
          cfg_n[BIT_CDR_EXT] = 1'b1;
          cfg_n[BIT_CDR_EN]  = 1'b0;
          cfg_n[BIT_CK_OUT]  = 1'b0;
          cfg_we             = 1'b1;
          phase_we           = 1'b1;
          arm                = 1'b1;
          state_n            = ST_WAIT_OFF;
        end
      end
      ST_WAIT_OFF, ST_WAIT_ON: begin
        if (expire) begin
          err_n   = 1'b1;
          state_n = ST_IDLE;
        end else if (hit) begin
          state_n = (state_q == ST_WAIT_OFF) ? ST_WR_PHASE : ST_FINISH;
        end
      end
      ST_WR_PHASE: begin
        cfg_n[FIELD_LO +: PH_W] = gray_w;
        cfg_we                  = 1'b1;
        state_n                 = ST_SET_OUT;
      end
      ST_SET_OUT: begin
        cfg_n[BIT_CK_OUT] = 1'b1;
        cfg_we            = 1'b1;
        arm               = 1'b1;
        state_n           = ST_WAIT_ON;
      end
      ST_FINISH: begin
        cfg_n[BIT_CDR_EN]  = 1'b1;
        cfg_n[BIT_CDR_EXT] = 1'b0;
        cfg_we             = 1'b1;
        done_n             = 1'b1;
        state_n            = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      phase_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      err_q   <= err_n;
      if (cfg_we)   cfg_q   <= cfg_n;
      if (phase_we) phase_q <= phase_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  // R2: start from idle raises busy with the gating update applied
  assert_start_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o && cfg_o[BIT_DLL_EN] && cfg_o[BIT_CDR_EXT]
                           && !cfg_o[BIT_CDR_EN] && !cfg_o[BIT_CK_OUT]);
  // R6: completion leaves recovery on, clock on, external select off
  assert_done_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cfg_o[BIT_DLL_EN] && cfg_o[BIT_CDR_EN] && cfg_o[BIT_CK_OUT]
               && !cfg_o[BIT_CDR_EXT] && !busy_o);
  // R7: an error ends the sequence
  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o);
  // R8: a start during a sequence does not replace the phase
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && busy_o |=> $stable(phase_q));
  // R9: unnamed bits hold while busy
  assert_other_bits_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable({cfg_o[CFG_W-1:FIELD_LO+PH_W], cfg_o[BIT_DLL_EN-1:0]}));
  // R10: single-cycle, exclusive completion pulses
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
endmodule

// File: tb/dll_phase_seq_test.sv
`timescale 1ns/1ps
module dll_phase_seq_test;
  localparam int unsigned POLL = 5;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [3:0]  phase_i;
  logic [31:0] cfg_base_i;
  logic        tick_i;
  logic        ck_stat_i;
  logic [31:0] cfg_o;
  logic        busy_o, done_o, err_o;

  int checks = 0;
  int fails  = 0;

  // status model: follows bit 18 after lag clocks, or stuck
  logic [15:0] pipe = '0;
  int          lag  = 0;
  int          mode = 0;   // 0 follow, 1 stuck at 1, 2 stuck at 0
  int          tdiv = 0;

  // per-run observations
  int nticks, ndone, nerr;

  // {phase, expected gray code, base word, lag}
  localparam logic [43:0] VEC [16] = '{
    {4'h0, 4'h0, 32'h0000_0000, 4'd0},
    {4'h1, 4'h1, 32'hFFFF_FFFF, 4'd1},
    {4'h2, 4'h3, 32'hA5A5_5A5A, 4'd2},
    {4'h3, 4'h2, 32'h1234_5678, 4'd3},
    {4'h4, 4'h6, 32'h8000_0001, 4'd4},
    {4'h5, 4'h7, 32'h00F0_0F00, 4'd5},
    {4'h6, 4'h5, 32'hDEAD_BEEF, 4'd6},
    {4'h7, 4'h4, 32'h0F0F_F0F0, 4'd7},
    {4'h8, 4'hC, 32'h5555_AAAA, 4'd8},
    {4'h9, 4'hD, 32'hCAFE_F00D, 4'd9},
    {4'hA, 4'hF, 32'h0101_0101, 4'd0},
    {4'hB, 4'hE, 32'hFEFE_FEFE, 4'd2},
    {4'hC, 4'hA, 32'h7777_8888, 4'd4},
    {4'hD, 4'hB, 32'h3C3C_C3C3, 4'd6},
    {4'hE, 4'h9, 32'h0000_FFFF, 4'd8},
    {4'hF, 4'h8, 32'hFFFF_0000, 4'd1}
  };

  always #4 clk = ~clk;

  always @(posedge clk) pipe <= {pipe[14:0], cfg_o[18]};
  assign ck_stat_i = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : pipe[lag];

  dll_phase_seq #(.POLL_CHECKS(POLL)) uut (
    .clk(clk), .rst_ni(rst_ni), .start_i(start_i), .phase_i(phase_i),
    .cfg_base_i(cfg_base_i), .tick_i(tick_i), .ck_stat_i(ck_stat_i),
    .cfg_o(cfg_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] w_gate(input logic [31:0] b);
    logic [31:0] r = b;
    r[16] = 1'b1; r[19] = 1'b1; r[17] = 1'b0; r[18] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] w_ok(input logic [31:0] b, input logic [3:0] g);
    logic [31:0] r = b;
    r[23:20] = g; r[16] = 1'b1; r[17] = 1'b1; r[18] = 1'b1; r[19] = 1'b0;
    return r;
  endfunction

  // one clock: note tick/busy before the edge, sample after it, set next tick
  task automatic cyc();
    logic t, b;
    t = tick_i; b = busy_o;
    @(posedge clk); #2;
    if (t && b) nticks++;
    if (done_o) ndone++;
    if (err_o)  nerr++;
    tdiv    = (tdiv + 1) % 3;
    tick_i  = (tdiv == 2);
  endtask

  task automatic launch(input logic [3:0] ph, input logic [31:0] base);
    nticks = 0; ndone = 0; nerr = 0;
    phase_i = ph; cfg_base_i = base; start_i = 1'b1;
    cyc();
    start_i = 1'b0;
    chk("R2 gating update", cfg_o, w_gate(base));
    chk("R2 busy after start", {31'd0, busy_o}, 32'd1);
  endtask

  task automatic finish_run();
    int guard = 0;
    while (busy_o && guard < 300) begin cyc(); guard++; end
    cyc();
    chk("R10 pulse dropped", {30'd0, done_o, err_o}, 32'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; phase_i = '0; cfg_base_i = '0; tick_i = 1'b0;
    #20;
    chk("R1 cfg in reset", cfg_o, 32'd0);
    chk("R1 flags in reset", {29'd0, busy_o, done_o, err_o}, 32'd0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (4) cyc();
    chk("R1 cfg after reset", cfg_o, 32'd0);
    chk("R1 flags after reset", {29'd0, busy_o, done_o, err_o}, 32'd0);

    // table walk: every phase code, varied base words and response lags (R4 R5 R6 R9)
    for (int i = 0; i < 16; i++) begin
      mode = 0; lag = int'(VEC[i][3:0]);
      launch(VEC[i][43:40], VEC[i][35:4]);
      finish_run();
      chk("R4 R6 R9 final word", cfg_o, w_ok(VEC[i][35:4], VEC[i][39:36]));
      chk("R6 R10 one done no error", {ndone[15:0], nerr[15:0]}, {16'd1, 16'd0});
    end

    // R8 R9: second start and base changes while busy are ignored
    mode = 0; lag = 5;
    launch(4'd3, 32'h2468_ACE0);
    cyc(); cyc();
    phase_i = 4'd12; cfg_base_i = 32'hFFFF_FFFF; start_i = 1'b1;
    cyc();
    start_i = 1'b0;
    finish_run();
    chk("R8 R9 ignored restart", cfg_o, w_ok(32'h2468_ACE0, 4'h2));
    chk("R8 single done", ndone, 32'd1);

    // R3 R7: status never drops, first poll expires after POLL ticks
    mode = 1;
    launch(4'd9, 32'h1357_9BDF);
    finish_run();
    chk("R7 error pulse", {ndone[15:0], nerr[15:0]}, {16'd0, 16'd1});
    chk("R7 ticks consumed", nticks, POLL);
    chk("R3 R7 no phase or clock write", cfg_o, w_gate(32'h1357_9BDF));

    // R5 R7: status never rises, second poll expires, final step skipped
    mode = 2;
    launch(4'd6, 32'h0A0B_0C0D);
    finish_run();
    chk("R7 error second poll", {ndone[15:0], nerr[15:0]}, {16'd0, 16'd1});
    begin
      logic [31:0] e;
      e = w_gate(32'h0A0B_0C0D); e[23:20] = 4'h5; e[18] = 1'b1;
      chk("R5 R7 word at second timeout", cfg_o, e);
    end

    // recovery after an error: a clean run still succeeds (R6)
    mode = 0; lag = 3;
    launch(4'd15, 32'h0000_0000);
    finish_run();
    chk("R6 run after error", cfg_o, w_ok(32'h0, 4'h8));
    chk("R6 done after error", {ndone[15:0], nerr[15:0]}, {16'd1, 16'd0});

    summary();
  end
endmodule